// File: doc/BRIEF.md
# Subgroup Issue Scheduler

This block decides, on every clock cycle, which resident thread subgroup of a compute unit may issue. It holds a table of resident slots. Each slot is empty, ready or parked, and keeps the subgroup identifier it was loaded with and the tag of the operation it is waiting on. When any thread of the issuing subgroup must wait, for example on a memory fetch, the pipeline reports a stall that names the slot and a tag. The whole subgroup is then parked. In that same cycle the scheduler moves to another ready subgroup, so the compute unit does not sit idle.

Completion events from the memory system carry a tag. Every parked slot waiting on that tag becomes ready again. Ready slots take turns in round-robin order, starting after the slot that issued last. Slots are filled by allocation requests, and the lowest free slot is always the one taken. A slot is freed only by an explicit retire. The occupancy output counts the resident slots out of the fixed maximum. When no slot can issue, the issue strobe stays low.

Top module: `sgs_issue_sched`

## Requirements
- R1: In the first cycle after a synchronous reset, no slot is resident, `occupancy` is 0 and `issue_valid` is 0.
- R2: While a slot is free, `alloc_valid` is accepted in the same cycle. `alloc_ok` goes high and `alloc_slot` gives the lowest-numbered free slot. That slot holds `alloc_id` and is ready from the next cycle on.
- R3: While all NSLOT (32) slots are resident, `alloc_ok` is 0 and `occupancy` stays at NSLOT.
- R4: Ready slots issue in round-robin order. The search starts at the slot after the last one issued and wraps from NSLOT-1 to 0. After reset the search starts at slot 0.
- R5: A stall whose `stall_slot` names a ready slot parks that slot with `stall_tag`. The named slot is not issued in the stall cycle, and it is not issued again while it is parked. Another ready slot issues in its place in the same cycle.
- R6: A completion with `done_tag` makes every parked slot whose tag matches ready from the next cycle on. Parked slots with other tags stay parked.
- R7: When no slot is eligible, `issue_valid` is 0 and `issue_slot` and `issue_id` are 0.
- R8: Retire frees the named slot from the next cycle on. The slot is not issued in the retire cycle, and `occupancy` drops by one.
- R9: `occupancy` equals the number of resident slots.
- R10: With a single resident slot that is parked, nothing issues until its completion arrives.
- R11: `issue_id` is the identifier that was stored in the issuing slot when it was allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to make a subgroup resident |
| alloc_id | input | ID_W | Subgroup identifier for the request |
| alloc_ok | output | 1 | The request is accepted this cycle |
| alloc_slot | output | SLOT_W | Slot given to the accepted request |
| stall_valid | input | 1 | The active subgroup must wait |
| stall_slot | input | SLOT_W | Slot of the stalling subgroup |
| stall_tag | input | TAG_W | Tag of the operation it waits on |
| done_valid | input | 1 | A pending operation completed |
| done_tag | input | TAG_W | Tag of the completed operation |
| retire_valid | input | 1 | Free a slot |
| retire_slot | input | SLOT_W | Slot to free |
| issue_valid | output | 1 | A subgroup issues this cycle |
| issue_slot | output | SLOT_W | Slot that issues |
| issue_id | output | ID_W | Identifier of the issuing subgroup |
| occupancy | output | OCC_W | Number of resident slots |

## Verification
The bound checker watches several rules on every cycle. A slot being stalled or retired never issues in that cycle. Nothing issues from an empty table. A refused allocation happens exactly when the table is full. Occupancy grows by one after each accepted allocation and never exceeds the maximum. The round-robin order, the wake-up of only the slots whose tag matches, the lowest-free-slot choice and the identifier carried into `issue_id` all depend on history. Only the bench's scripted stall, completion, retire and fill sequences show those, by comparing the issued identifiers against expectations queued from the requirements.

// File: rtl/sgs_pkg.sv
package sgs_pkg;

    localparam int DEF_NSLOT = 32;
    localparam int DEF_ID_W  = 6;
    localparam int DEF_TAG_W = 4;

    typedef enum logic [1:0] {
        SLOT_EMPTY  = 2'd0,
        SLOT_READY  = 2'd1,
        SLOT_PARKED = 2'd2
    } slot_state_e;

    // Wrapping successor of a slot index, in plain integers.
    function automatic int wrap_add(input int base, input int step, input int n);
        return (base + step) % n;
    endfunction

endpackage

// File: rtl/sgs_slot_table.sv
module sgs_slot_table
    import sgs_pkg::*;
#(
    parameter int NSLOT  = DEF_NSLOT,
    parameter int ID_W   = DEF_ID_W,
    parameter int TAG_W  = DEF_TAG_W,
    localparam int SLOT_W = $clog2(NSLOT),
    localparam int OCC_W  = $clog2(NSLOT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [ID_W-1:0]   alloc_id,
    output logic              alloc_ok,
    output logic [SLOT_W-1:0] alloc_slot,
    input  logic              stall_valid,
    input  logic [SLOT_W-1:0] stall_slot,
    input  logic [TAG_W-1:0]  stall_tag,
    input  logic              done_valid,
    input  logic [TAG_W-1:0]  done_tag,
    input  logic              retire_valid,
    input  logic [SLOT_W-1:0] retire_slot,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [ID_W-1:0]   rd_id,
    output logic [NSLOT-1:0]  ready_mask,
    output logic [OCC_W-1:0]  occupancy
);

    slot_state_e       st_q  [NSLOT];
    logic [TAG_W-1:0]  tag_q [NSLOT];
    logic [ID_W-1:0]   id_q  [NSLOT];

    logic              any_free;

    // Lowest free slot: scan from the top so the last hit is the smallest.
    always_comb begin
        any_free   = 1'b0;
        alloc_slot = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (st_q[i] == SLOT_EMPTY) begin
                any_free   = 1'b1;
                alloc_slot = SLOT_W'(i);
            end
        end
    end

    assign alloc_ok = alloc_valid && any_free;

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_slot
            logic hit_retire, hit_alloc, hit_stall, hit_done;

            assign hit_retire = retire_valid && (retire_slot == SLOT_W'(g));
            assign hit_alloc  = alloc_ok && (alloc_slot == SLOT_W'(g));
            assign hit_stall  = stall_valid && (stall_slot == SLOT_W'(g))
                                && (st_q[g] == SLOT_READY);
            assign hit_done   = done_valid && (st_q[g] == SLOT_PARKED)
                                && (tag_q[g] == done_tag);

            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q[g]  <= SLOT_EMPTY;
                    tag_q[g] <= '0;
                    id_q[g]  <= '0;
                end else if (hit_retire) begin
                    st_q[g] <= SLOT_EMPTY;
                end else if (hit_alloc) begin
                    st_q[g] <= SLOT_READY;
                    id_q[g] <= alloc_id;
                end else if (hit_stall) begin
                    st_q[g]  <= SLOT_PARKED;
                    tag_q[g] <= stall_tag;
                end else if (hit_done) begin
                    st_q[g] <= SLOT_READY;
                end
            end

            assign ready_mask[g] = (st_q[g] == SLOT_READY);
        end
    endgenerate

    always_comb begin
        occupancy = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (st_q[i] != SLOT_EMPTY) occupancy = occupancy + OCC_W'(1);
        end
    end

    assign rd_id = id_q[rd_slot];

endmodule

// File: rtl/sgs_rr_pick.sv
module sgs_rr_pick
    import sgs_pkg::*;
#(
    parameter int NSLOT  = DEF_NSLOT,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSLOT-1:0]  cand,
    output logic              pick_valid,
    output logic [SLOT_W-1:0] pick_idx
);

    logic [SLOT_W-1:0] last_q;

    // Search starts one past the last issued slot and wraps.
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int k = 1; k <= NSLOT; k++) begin
            int idx;
            idx = wrap_add(int'(last_q), k, NSLOT);
            if (!pick_valid && cand[idx]) begin
                pick_valid = 1'b1;
                pick_idx   = SLOT_W'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             last_q <= SLOT_W'(NSLOT - 1);
        else if (pick_valid) last_q <= pick_idx;
    end

endmodule

// File: rtl/sgs_issue_sched.sv
module sgs_issue_sched
    import sgs_pkg::*;
#(
    parameter int NSLOT  = DEF_NSLOT,
    parameter int ID_W   = DEF_ID_W,
    parameter int TAG_W  = DEF_TAG_W,
    localparam int SLOT_W = $clog2(NSLOT),
    localparam int OCC_W  = $clog2(NSLOT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [ID_W-1:0]   alloc_id,
    output logic              alloc_ok,
    output logic [SLOT_W-1:0] alloc_slot,
    input  logic              stall_valid,
    input  logic [SLOT_W-1:0] stall_slot,
    input  logic [TAG_W-1:0]  stall_tag,
    input  logic              done_valid,
    input  logic [TAG_W-1:0]  done_tag,
    input  logic              retire_valid,
    input  logic [SLOT_W-1:0] retire_slot,
    output logic              issue_valid,
    output logic [SLOT_W-1:0] issue_slot,
    output logic [ID_W-1:0]   issue_id,
    output logic [OCC_W-1:0]  occupancy
);

    logic [NSLOT-1:0]  ready_mask;
    logic [NSLOT-1:0]  block_mask;
    logic [NSLOT-1:0]  cand;
    logic              pick_valid;
    logic [SLOT_W-1:0] pick_idx;
    logic [ID_W-1:0]   pick_id;

    // A slot being parked or freed this cycle steps aside at once.
    always_comb begin
        block_mask = '0;
        if (stall_valid)  block_mask[stall_slot]  = 1'b1;
        if (retire_valid) block_mask[retire_slot] = 1'b1;
    end

    assign cand = ready_mask & ~block_mask;

    sgs_slot_table #(.NSLOT(NSLOT), .ID_W(ID_W), .TAG_W(TAG_W)) u_table (
        .clk          (clk),
        .rst          (rst),
        .alloc_valid  (alloc_valid),
        .alloc_id     (alloc_id),
        .alloc_ok     (alloc_ok),
        .alloc_slot   (alloc_slot),
        .stall_valid  (stall_valid),
        .stall_slot   (stall_slot),
        .stall_tag    (stall_tag),
        .done_valid   (done_valid),
        .done_tag     (done_tag),
        .retire_valid (retire_valid),
        .retire_slot  (retire_slot),
        .rd_slot      (pick_idx),
        .rd_id        (pick_id),
        .ready_mask   (ready_mask),
        .occupancy    (occupancy)
    );

    sgs_rr_pick #(.NSLOT(NSLOT)) u_pick (
        .clk        (clk),
        .rst        (rst),
        .cand       (cand),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    assign issue_valid = pick_valid;
    assign issue_slot  = pick_valid ? pick_idx : '0;
    assign issue_id    = pick_valid ? pick_id  : '0;

endmodule

// File: rtl/sgs_issue_sched_chk.sv
module sgs_issue_sched_chk #(
    parameter int NSLOT  = 32,
    parameter int ID_W   = 6,
    parameter int TAG_W  = 4,
    localparam int SLOT_W = $clog2(NSLOT),
    localparam int OCC_W  = $clog2(NSLOT + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              alloc_valid,
    input logic [ID_W-1:0]   alloc_id,
    input logic              alloc_ok,
    input logic [SLOT_W-1:0] alloc_slot,
    input logic              stall_valid,
    input logic [SLOT_W-1:0] stall_slot,
    input logic [TAG_W-1:0]  stall_tag,
    input logic              done_valid,
    input logic [TAG_W-1:0]  done_tag,
    input logic              retire_valid,
    input logic [SLOT_W-1:0] retire_slot,
    input logic              issue_valid,
    input logic [SLOT_W-1:0] issue_slot,
    input logic [ID_W-1:0]   issue_id,
    input logic [OCC_W-1:0]  occupancy
);

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (occupancy == '0 && !issue_valid));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        occupancy <= OCC_W'(NSLOT));

    a_r3_full_refuse: assert property (@(posedge clk) disable iff (rst)
        alloc_valid |-> (alloc_ok == (occupancy != OCC_W'(NSLOT))));

    a_r9_alloc_grow: assert property (@(posedge clk) disable iff (rst)
        (alloc_ok && !retire_valid) |=> (occupancy == $past(occupancy) + OCC_W'(1)));

    a_r5_stall_steps_aside: assert property (@(posedge clk) disable iff (rst)
        stall_valid |-> !(issue_valid && issue_slot == stall_slot));

    a_r8_retire_steps_aside: assert property (@(posedge clk) disable iff (rst)
        retire_valid |-> !(issue_valid && issue_slot == retire_slot));

    a_r10_empty_idle: assert property (@(posedge clk) disable iff (rst)
        (occupancy == '0) |-> !issue_valid);

    a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |-> (issue_slot == '0 && issue_id == '0));

endmodule

bind sgs_issue_sched sgs_issue_sched_chk #(
    .NSLOT(NSLOT), .ID_W(ID_W), .TAG_W(TAG_W)
) u_chk (.*);

// File: tb/sgs_issue_sched_test.sv
module sgs_issue_sched_test;

    localparam int NSLOT = 32;
    localparam int ID_W  = 6;
    localparam int TAG_W = 4;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int OCC_W  = $clog2(NSLOT + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              alloc_valid = 1'b0;
    logic [ID_W-1:0]   alloc_id = '0;
    logic              alloc_ok;
    logic [SLOT_W-1:0] alloc_slot;
    logic              stall_valid = 1'b0;
    logic [SLOT_W-1:0] stall_slot = '0;
    logic [TAG_W-1:0]  stall_tag = '0;
    logic              done_valid = 1'b0;
    logic [TAG_W-1:0]  done_tag = '0;
    logic              retire_valid = 1'b0;
    logic [SLOT_W-1:0] retire_slot = '0;
    logic              issue_valid;
    logic [SLOT_W-1:0] issue_slot;
    logic [ID_W-1:0]   issue_id;
    logic [OCC_W-1:0]  occupancy;

    always #10 clk = ~clk;

    sgs_issue_sched #(.NSLOT(NSLOT), .ID_W(ID_W), .TAG_W(TAG_W)) uut (.*);

    // Scoreboard items: kind 0 = issued id (-1 idle), 1 = occupancy, 2 = grant slot (-1 refused)
    typedef struct {
        int    kind;
        int    value;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   checks   = 0;
    int   failures = 0;
    bit   finished = 1'b0;

    function automatic void push(input int kind, input int value, input string req);
        exp_t e;
        e.kind = kind; e.value = value; e.req = req;
        exp_q.push_back(e);
    endfunction

    // Monitor: samples the combinational outputs mid-cycle and pops expectations.
    always @(negedge clk) begin
        #5;
        while (exp_q.size() > 0) begin
            exp_t e;
            int   act;
            e = exp_q.pop_front();
            case (e.kind)
                0:       act = issue_valid ? int'(issue_id) : -1;
                1:       act = int'(occupancy);
                default: act = alloc_ok ? int'(alloc_slot) : -1;
            endcase
            checks++;
            if (act != e.value) begin
                failures++;
                $display("FAIL %s kind=%0d actual=%0d expected=%0d at %0t",
                         e.req, e.kind, act, e.value, $time);
            end
        end
    end

    task automatic clr();
        alloc_valid = 1'b0; stall_valid = 1'b0; done_valid = 1'b0; retire_valid = 1'b0;
    endtask

    task automatic cyc();
        @(negedge clk);
        clr();
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: empty after reset
        cyc(); push(0, -1, "R1"); push(1, 0, "R1");
        // R2: allocations take the lowest free slot
        cyc(); alloc_valid = 1; alloc_id = 10; push(2, 0, "R2"); push(0, -1, "R7");
        cyc(); alloc_valid = 1; alloc_id = 11; push(2, 1, "R2"); push(0, 10, "R4"); push(1, 1, "R9");
        cyc(); alloc_valid = 1; alloc_id = 12; push(2, 2, "R2"); push(0, 11, "R4"); push(1, 2, "R9");
        // R4: round robin with wrap
        cyc(); push(0, 12, "R4"); push(1, 3, "R9");
        cyc(); push(0, 10, "R4");
        // R5: stalls park and switch at once
        cyc(); stall_valid = 1; stall_slot = 0; stall_tag = 3; push(0, 11, "R5");
        cyc(); stall_valid = 1; stall_slot = 1; stall_tag = 5; push(0, 12, "R5");
        cyc(); stall_valid = 1; stall_slot = 2; stall_tag = 3; push(0, -1, "R7");
        // R6: completion tag 3 wakes slots 0 and 2 only
        cyc(); done_valid = 1; done_tag = 3; push(0, -1, "R6");
        cyc(); push(0, 10, "R6");
        cyc(); push(0, 12, "R6");
        cyc(); push(0, 10, "R6");
        cyc(); done_valid = 1; done_tag = 5; push(0, 12, "R6");
        cyc(); push(0, 10, "R4");
        cyc(); push(0, 11, "R11");
        // R8: retires
        cyc(); retire_valid = 1; retire_slot = 1; push(0, 12, "R8"); push(1, 3, "R8");
        cyc(); push(0, 10, "R8"); push(1, 2, "R8");
        cyc(); retire_valid = 1; retire_slot = 0; push(0, 12, "R8");
        cyc(); retire_valid = 1; retire_slot = 2; push(0, -1, "R8"); push(1, 1, "R8");
        cyc(); push(0, -1, "R7"); push(1, 0, "R8");
        // R10: single resident, stalled
        cyc(); alloc_valid = 1; alloc_id = 20; push(2, 0, "R2");
        cyc(); stall_valid = 1; stall_slot = 0; stall_tag = 7; push(0, -1, "R10"); push(1, 1, "R9");
        cyc(); push(0, -1, "R10");
        cyc(); push(0, -1, "R10");
        cyc(); done_valid = 1; done_tag = 7; push(0, -1, "R10");
        cyc(); push(0, 20, "R10");
        // R3: fill to the limit, then refuse
        for (int k = 1; k < NSLOT; k++) begin
            cyc(); alloc_valid = 1; alloc_id = ID_W'(32 + k); push(2, k, "R2");
        end
        cyc(); alloc_valid = 1; alloc_id = 1; push(2, -1, "R3"); push(1, NSLOT, "R3");
        cyc(); retire_valid = 1; retire_slot = 5; push(1, NSLOT, "R3");
        cyc(); alloc_valid = 1; alloc_id = 9; push(2, 5, "R2"); push(1, NSLOT - 1, "R8");
        cyc(); push(1, NSLOT, "R9");
        cyc(); cyc();
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule